// File: doc/BRIEF.md
# Lockable Timer/Counter

A timer/counter peripheral on a simple 32-bit register bus. Software picks a counter size of 8, 16 or 32 bits, a clock division ratio, a counting direction, an optional single-pass mode, and per-channel capture and polarity settings. It then starts the counter with the run bit. While running, the counter steps once per prescaled tick. It wraps at the limit for its size and gives a one-cycle overflow pulse on each wrap. A level that toggles on every wrap drives the channel outputs.

The configuration fields are locked while the counter runs, and the block enforces the lock itself. A single write may load the locked fields and start the counter at the same time. A write that stops the counter cannot change them. The run bit and the software-reset bit are never locked. A channel in capture mode stores the count on a rising edge of its input after polarity inversion. Its captured value is read back over the bus.

Top module: `lockable_timer`

Register map (word addresses on `bus_addr`):
- 0 CONTROL: bit 0 run, bit 1 software reset (write-only, reads 0), bits 3:2 size code, bits 6:4 prescale code, bits 8 and up are the capture enables (one per channel). Everything except bits 1:0 is locked.
- 1 MODE: bit 0 count down, bit 1 one-shot. Never locked.
- 2 INVERT: one polarity bit per channel. Locked.
- 3 WAVE: bits 1:0, a stored waveform selection. Locked.
- 4 EVENT: bits 3:0, a stored event selection. Locked.
- 5 COUNT: the current count, read-only.
- 8 + n: the capture value of channel n, read-only.

## Requirements
- R1: After reset the run bit is 0, the size code is 1 (16-bit), and the prescale code, MODE, INVERT, WAVE, EVENT and capture enables are 0. CONTROL reads 0x4, the count is 0, `ovf_pulse` is 0 and `ch_out` is all zeros.
- R2: CONTROL bits above bit 1, INVERT, WAVE and EVENT can be written while the run bit is 0. A write to any of them while the run bit is 1 is ignored, and readback returns the old value.
- R3: A CONTROL write with bit 0 = 1 while stopped loads the locked CONTROL fields and sets the run bit in the same write.
- R4: A CONTROL write with bit 0 = 0 while running clears the run bit, leaves every locked field unchanged, and freezes the count.
- R5: Writing 1 to CONTROL bit 1 returns all registers, the count and the capture values to their reset values, whether or not the counter is running.
- R6: The count loads its start value one cycle after the run bit rises. It then steps once every N cycles, where prescale codes 0 to 7 select N = 1, 2, 4, 8, 16, 64, 256 and 1024. The first step comes N cycles after the load.
- R7: Size codes 0, 1 and 2 (3 acts as 2) give TOP = 0xFF, 0xFFFF and 0xFFFFFFFF. Counting up starts at 0 and wraps from TOP to 0. Each wrap makes `ovf_pulse` 1 for exactly one cycle.
- R8: With MODE bit 0 set, the count starts at TOP and decrements, wraps from 0 to TOP, and pulses `ovf_pulse` on each wrap.
- R9: With MODE bit 1 set, the step that reaches the limit (TOP going up, 0 going down) pulses `ovf_pulse`, holds the count at the limit and clears the run bit.
- R10: The wave level starts at 0 when the counter starts and toggles on every wrap. Each channel with capture disabled drives `ch_out` = wave level XOR its INVERT bit.
- R11: A channel with its capture enable set drives `ch_out` 0. While the counter runs, that channel stores the current count on each rising edge of (`ch_in` XOR its INVERT bit). The stored value reads back at address 8 + channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for write and readback |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Readback of `bus_addr`, one cycle later |
| ch_in | input | NCH | Channel inputs for capture |
| ch_out | output | NCH | Channel outputs |
| count_value | output | 32 | Current count |
| ovf_pulse | output | 1 | One-cycle pulse on each wrap |

## Verification
The counter is run with up and down counting in each size, with every prescale ratio, and in both free-running and one-shot modes, and is compared with the expected count and overflow every cycle. An up run in 8-bit mode and in 16-bit mode over the same 300 cycles separates a correct wrap at TOP from a wrap at the wrong size. A down run separates the start value and the wrap from 0 to TOP. The one-shot run separates holding at the limit from wrapping. Lock testing writes each locked register while running, then sets and clears the run bit together with new field values, which separates the allowed combined start from the refused combined stop. The capture run uses a slow ratio so the stored count is known, and an inverted channel shows that the falling input edge is the one that captures.

// File: rtl/lockable_timer_pkg.sv
package lockable_timer_pkg;
  localparam int CNT_W  = 32;
  localparam int PCNT_W = 10;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_MODE = 4'd1;
  localparam logic [3:0] A_INV  = 4'd2;
  localparam logic [3:0] A_WAVE = 4'd3;
  localparam logic [3:0] A_EVT  = 4'd4;
  localparam logic [3:0] A_CNT  = 4'd5;
  localparam logic [3:0] A_CAP0 = 4'd8;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_32B = 2'd3
  } size_e;

  function automatic logic [CNT_W-1:0] top_of(input logic [1:0] sz);
    case (size_e'(sz))
      SZ_8:    top_of = 32'h0000_00FF;
      SZ_16:   top_of = 32'h0000_FFFF;
      default: top_of = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [PCNT_W-1:0] ratio_m1(input logic [2:0] code);
    case (code)
      3'd0:    ratio_m1 = 10'd0;
      3'd1:    ratio_m1 = 10'd1;
      3'd2:    ratio_m1 = 10'd3;
      3'd3:    ratio_m1 = 10'd7;
      3'd4:    ratio_m1 = 10'd15;
      3'd5:    ratio_m1 = 10'd63;
      3'd6:    ratio_m1 = 10'd255;
      default: ratio_m1 = 10'd1023;
    endcase
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lockable_timer_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              os_stop,
  output logic              sw_clr,
  output logic              run_q,
  output logic [1:0]        size_q,
  output logic [2:0]        pres_q,
  output logic [NCH-1:0]    capen_q,
  output logic              down_q,
  output logic              oneshot_q,
  output logic [NCH-1:0]    inv_q,
  output logic [1:0]        wave_sel_q,
  output logic [3:0]        evt_sel_q
);
  logic wr_ctrl, wr_mode, wr_inv, wr_wave, wr_evt;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_mode = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign wr_inv  = bus_wr && (bus_addr == ADDR_W'(A_INV));
  assign wr_wave = bus_wr && (bus_addr == ADDR_W'(A_WAVE));
  assign wr_evt  = bus_wr && (bus_addr == ADDR_W'(A_EVT));
  assign sw_clr  = wr_ctrl && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (rst || sw_clr) begin
      run_q      <= 1'b0;
      size_q     <= SZ_16;
      pres_q     <= '0;
      capen_q    <= '0;
      down_q     <= 1'b0;
      oneshot_q  <= 1'b0;
      inv_q      <= '0;
      wave_sel_q <= '0;
      evt_sel_q  <= '0;
    end else begin
      // the run bit is always writable; the rest only while stopped
      if (wr_ctrl) begin
        run_q <= bus_wdata[0];
        if (!run_q) begin
          size_q  <= bus_wdata[3:2];
          pres_q  <= bus_wdata[6:4];
          capen_q <= bus_wdata[8 +: NCH];
        end
      end else if (os_stop) begin
        run_q <= 1'b0;
      end
      if (wr_mode) begin
        down_q    <= bus_wdata[0];
        oneshot_q <= bus_wdata[1];
      end
      if (wr_inv && !run_q)  inv_q      <= bus_wdata[NCH-1:0];
      if (wr_wave && !run_q) wave_sel_q <= bus_wdata[1:0];
      if (wr_evt && !run_q)  evt_sel_q  <= bus_wdata[3:0];
    end
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lockable_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PCNT_W-1:0] pcnt;

  assign tick = active && (pcnt == ratio_m1(code));

  always_ff @(posedge clk) begin
    if (rst || !active) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/lt_core.sv
module lt_core
  import lockable_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       size,
  input  logic             down,
  input  logic             oneshot,
  output logic             active,
  output logic             os_stop,
  output logic             wave_q,
  output logic             ovf_q,
  output logic [CNT_W-1:0] count_q
);
  logic             run_prev;
  logic             start;
  logic [CNT_W-1:0] top, limit, wrap_to;
  logic             wrap;

  assign top     = top_of(size);
  assign limit   = down ? '0 : top;
  assign wrap_to = down ? top : '0;
  assign start   = run && !run_prev;
  assign active  = run && run_prev;
  assign wrap    = tick && (count_q == limit);
  assign os_stop = wrap && oneshot;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_prev <= 1'b0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
      wave_q   <= 1'b0;
    end else begin
      run_prev <= run;
      ovf_q    <= wrap;
      if (start) begin
        count_q <= wrap_to;
        wave_q  <= 1'b0;
      end else if (wrap) begin
        wave_q <= ~wave_q;
        if (!oneshot) count_q <= wrap_to;
      end else if (tick) begin
        count_q <= down ? count_q - 1'b1 : count_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lt_channels.sv
module lt_channels
  import lockable_timer_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 active,
  input  logic [NCH-1:0]       capen,
  input  logic [NCH-1:0]       inv,
  input  logic [NCH-1:0]       ch_in,
  input  logic                 wave,
  input  logic [CNT_W-1:0]     count,
  output logic [NCH-1:0]       ch_out,
  output logic [NCH*CNT_W-1:0] cap_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sig, prev_q;
    assign sig = ch_in[i] ^ inv[i];

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        prev_q                  <= 1'b0;
        ch_out[i]               <= 1'b0;
        cap_flat[i*CNT_W +: CNT_W] <= '0;
      end else begin
        prev_q    <= sig;
        ch_out[i] <= capen[i] ? 1'b0 : (wave ^ inv[i]);
        if (active && capen[i] && sig && !prev_q)
          cap_flat[i*CNT_W +: CNT_W] <= count;
      end
    end
  end
endmodule

// File: rtl/lockable_timer.sv
module lockable_timer
  import lockable_timer_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ch_in,
  output logic [NCH-1:0]    ch_out,
  output logic [31:0]       count_value,
  output logic              ovf_pulse
);
  logic                 sw_clr, run_q, down_q, oneshot_q;
  logic [1:0]           size_q, wave_sel_q;
  logic [2:0]           pres_q;
  logic [3:0]           evt_sel_q;
  logic [NCH-1:0]       capen_q, inv_q;
  logic                 os_stop, tick, active, wave_q;
  logic [NCH*CNT_W-1:0] cap_flat;
  logic [31:0]          rd_next;

  lt_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .os_stop(os_stop), .sw_clr(sw_clr),
    .run_q(run_q), .size_q(size_q), .pres_q(pres_q), .capen_q(capen_q),
    .down_q(down_q), .oneshot_q(oneshot_q), .inv_q(inv_q),
    .wave_sel_q(wave_sel_q), .evt_sel_q(evt_sel_q)
  );

  lt_prescaler u_pres (
    .clk(clk), .rst(rst || sw_clr), .active(active), .code(pres_q), .tick(tick)
  );

  lt_core u_core (
    .clk(clk), .rst(rst), .clr(sw_clr), .run(run_q), .tick(tick),
    .size(size_q), .down(down_q), .oneshot(oneshot_q), .active(active),
    .os_stop(os_stop), .wave_q(wave_q), .ovf_q(ovf_pulse), .count_q(count_value)
  );

  lt_channels #(.NCH(NCH)) u_chan (
    .clk(clk), .rst(rst), .clr(sw_clr), .active(active), .capen(capen_q),
    .inv(inv_q), .ch_in(ch_in), .wave(wave_q), .count(count_value),
    .ch_out(ch_out), .cap_flat(cap_flat)
  );

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): begin
        rd_next[0]        = run_q;
        rd_next[3:2]      = size_q;
        rd_next[6:4]      = pres_q;
        rd_next[8 +: NCH] = capen_q;
      end
      ADDR_W'(A_MODE): rd_next[1:0]     = {oneshot_q, down_q};
      ADDR_W'(A_INV):  rd_next[NCH-1:0] = inv_q;
      ADDR_W'(A_WAVE): rd_next[1:0]     = wave_sel_q;
      ADDR_W'(A_EVT):  rd_next[3:0]     = evt_sel_q;
      ADDR_W'(A_CNT):  rd_next          = count_value;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == ADDR_W'(A_CAP0) + ADDR_W'(i))
            rd_next = cap_flat[i*CNT_W +: CNT_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/lockable_timer_chk.sv
module lockable_timer_chk
  import lockable_timer_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              run_q,
  input logic              sw_clr,
  input logic [1:0]        size_q,
  input logic [2:0]        pres_q,
  input logic [NCH-1:0]    capen_q,
  input logic [NCH-1:0]    inv_q,
  input logic              down_q,
  input logic              oneshot_q,
  input logic              os_stop,
  input logic              tick,
  input logic [31:0]       count_value,
  input logic              ovf_pulse,
  input logic [NCH-1:0]    ch_out
);
  // R2
  inv_locked_chk: assert property (@(posedge clk) disable iff (rst)
    run_q && bus_wr && bus_addr == ADDR_W'(A_INV) |=> $stable(inv_q));

  // R4
  stop_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    run_q && bus_wr && bus_addr == ADDR_W'(A_CTRL) && !bus_wdata[0] && !bus_wdata[1]
    |=> !run_q && $stable(size_q) && $stable(pres_q) && $stable(capen_q));

  // R4
  stopped_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q && !sw_clr |=> $stable(count_value));

  // R7
  ovf_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(tick));

  // R8
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick && down_q && !oneshot_q && count_value == '0 && !sw_clr
    |=> count_value == top_of(size_q));

  // R9
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
    os_stop && !bus_wr |=> !run_q);

  // R11
  capture_out_low_chk: assert property (@(posedge clk) disable iff (rst)
    capen_q != '0 |=> (ch_out & $past(capen_q)) == '0);
endmodule

bind lockable_timer lockable_timer_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run_q(run_q), .sw_clr(sw_clr), .size_q(size_q),
  .pres_q(pres_q), .capen_q(capen_q), .inv_q(inv_q), .down_q(down_q),
  .oneshot_q(oneshot_q), .os_stop(os_stop), .tick(tick),
  .count_value(count_value), .ovf_pulse(ovf_pulse), .ch_out(ch_out)
);

// File: tb/lockable_timer_tb.sv
`timescale 1ns/1ps
module lockable_timer_tb;
  localparam int NCH = 2;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] ch_in = '0;
  logic [NCH-1:0] ch_out;
  logic [31:0]    count_value;
  logic           ovf_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lockable_timer #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in),
    .ch_out(ch_out), .count_value(count_value), .ovf_pulse(ovf_pulse)
  );

  function automatic int ratio_of(int code);
    int t[8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
    return t[code];
  endfunction

  function automatic logic [31:0] top_val(int sz);
    if (sz == 0) return 32'hFF;
    if (sz == 1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] ctl(bit run, int sz, int pc, int cap);
    return 32'(run) | 32'(sz << 2) | 32'(pc << 4) | 32'(cap << 8);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_check(string tag, int sz, int pc, bit dn, bit os, int n);
    int r = ratio_of(pc);
    logic [31:0] top = top_val(sz);
    logic [31:0] start = dn ? top : 32'h0;
    logic [31:0] lim = dn ? 32'h0 : top;
    logic [31:0] e = start;
    bit stopped = 0;
    bit eovf;
    wr(4'd1, {30'd0, os, dn});
    wr(4'd0, ctl(1, sz, pc, 0));
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      eovf = 0;
      if (k >= 2 && !stopped && ((k - 2) % r) == r - 1) begin
        if (e == lim) begin
          eovf = 1;
          if (os) stopped = 1;
          else    e = start;
        end else begin
          e = dn ? e - 1 : e + 1;
        end
      end
      chk({tag, " count"}, count_value, e);
      chk({tag, " overflow"}, {31'd0, ovf_pulse}, {31'd0, eovf});
    end
    if (!os) wr(4'd0, ctl(0, sz, pc, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0, c1;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: defaults
    chk("R1 count", count_value, 0);
    chk("R1 ovf", {31'd0, ovf_pulse}, 0);
    chk("R1 ch_out", {30'd0, ch_out}, 0);
    rd(4'd0, d); chk("R1 control", d, 32'h4);
    rd(4'd2, d); chk("R1 invert", d, 0);

    // R2: locked fields writable while stopped
    wr(4'd3, 32'h1); wr(4'd4, 32'h5); wr(4'd2, 32'h1);
    rd(4'd3, d); chk("R2 wave stopped", d, 32'h1);
    rd(4'd4, d); chk("R2 event stopped", d, 32'h5);

    // R7: 8-bit up wrap; R10: wave after one wrap, inverted ch0
    run_check("R7 8bit up", 0, 0, 0, 0, 300);
    @(negedge clk);
    chk("R10 ch_out", {30'd0, ch_out}, 32'h2);

    // R3: start with new locked fields in one write
    wr(4'd1, 32'h0);
    wr(4'd0, ctl(1, 2, 3, 0));
    rd(4'd0, d); chk("R3 combined start", d, 32'h39);
    // R2: locked while running
    wr(4'd0, ctl(1, 0, 5, 3));
    rd(4'd0, d); chk("R2 control locked", d, 32'h39);
    wr(4'd2, 32'h2); rd(4'd2, d); chk("R2 invert locked", d, 32'h1);
    wr(4'd3, 32'h2); rd(4'd3, d); chk("R2 wave locked", d, 32'h1);
    wr(4'd4, 32'hA); rd(4'd4, d); chk("R2 event locked", d, 32'h5);
    // R4: stop refuses new fields, count frozen
    wr(4'd0, ctl(0, 0, 5, 3));
    rd(4'd0, d); chk("R4 stop keeps fields", d, 32'h38);
    rd(4'd5, c0);
    repeat (20) @(negedge clk);
    rd(4'd5, c1);
    chk("R4 count frozen", c1, c0);

    // R8: down counting, 8-bit wrap and 32-bit start
    run_check("R8 8bit down", 0, 0, 1, 0, 300);
    run_check("R8 32bit down", 2, 0, 1, 0, 20);
    // R7: 16-bit passes 0xFF without wrapping
    run_check("R7 16bit up", 1, 0, 0, 0, 300);

    // R9: one-shot holds at limit and clears run
    run_check("R9 oneshot", 0, 0, 0, 1, 300);
    rd(4'd0, d); chk("R9 run cleared", d, 32'h0);
    wr(4'd1, 32'h0);

    // R6: random sizes, ratios and directions
    for (int it = 0; it < 8; it++) begin
      int sz = int'($urandom % 3);
      int pc = int'($urandom % 8);
      bit dn = bit'($urandom % 2);
      int n  = 200 + int'($urandom % 400);
      run_check("R6 random", sz, pc, dn, 0, n);
    end
    run_check("R6 ratio 16", 0, 4, 0, 0, 100);

    // R11: capture with ch1 inverted
    wr(4'd2, 32'h2);
    wr(4'd1, 32'h0);
    wr(4'd0, ctl(1, 1, 7, 3));
    repeat (1100) @(negedge clk);
    ch_in = 2'b11;
    repeat (1000) @(negedge clk);
    ch_in = 2'b01;
    repeat (5) @(negedge clk);
    rd(4'd8, d); chk("R11 capture ch0", d, 32'h1);
    rd(4'd9, d); chk("R11 capture ch1 inverted", d, 32'h2);
    chk("R11 ch_out low", {30'd0, ch_out}, 0);

    // R5: software reset while running
    wr(4'd5, 32'h0);
    repeat (10) @(negedge clk);
    wr(4'd0, 32'h3);
    rd(4'd0, d); chk("R5 control", d, 32'h4);
    rd(4'd5, d); chk("R5 count", d, 0);
    rd(4'd2, d); chk("R5 invert", d, 0);
    rd(4'd3, d); chk("R5 wave", d, 0);
    rd(4'd4, d); chk("R5 event", d, 0);
    rd(4'd8, d); chk("R5 capture", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule